// File: doc/BRIEF.md
# Gauss-Jordan Phase and Row Sequencer

This block is the global pacing unit of a row-parallel Gauss-Jordan linear solver. Each row of the system lives in its own processing element; every element watches a shared phase code and a shared reference-row index, works out its own task from them, and raises its bit of a done vector when it has finished. The sequencer moves the index forward once all participating elements have finished. At the end of a row sweep it moves on to the next phase.

A run begins with a start pulse and a system size between 1 and the built-in maximum (26 by default). The size is captured at that moment, so one hardware build can solve any smaller system. The run sweeps the reference row from 1 to n three times: once to load the rows, once to eliminate one unknown per step, and once to hand the results back. It then emits a single-cycle finished pulse and returns to idle. Done bits of elements at or above the active size take no part in the decision to advance.

Top module: `gj_phase_sequencer`

## Requirements
- R1: After reset, phase_o is 0 (idle), ref_row_o is 0, busy_o is 0 and finished_o is 0.
- R2: A start_i seen while idle with size_i in 1..MAX_ROWS gives, on the next cycle, phase_o = 1 (initialization), ref_row_o = 1 and busy_o = 1.
- R3: A start_i seen while idle with size_i equal to 0 or greater than MAX_ROWS is ignored, and the block stays idle.
- R4: While busy, ref_row_o advances only in a cycle where done_i bits 0..n-1 are all high (bit k belongs to row k+1). Bits at index n and above are ignored. If any active bit is low, phase_o and ref_row_o hold.
- R5: When a step completes with ref_row_o = n, ref_row_o goes back to 1 and the phase advances in the order 1 (initialization), 2 (elimination), 3 (return). Each phase therefore lasts exactly n steps.
- R6: Completing row n in the return phase gives, on the next cycle, phase_o = 0, ref_row_o = 0 and busy_o = 0, with finished_o high for exactly that one cycle.
- R7: A start_i seen while busy is ignored. This includes a start_i in the same cycle as the final step of a run.
- R8: The active size is the value captured when the run starts. Changes on size_i during a run have no effect.
- R9: While busy, ref_row_o always lies between 1 and n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a solve |
| size_i | input | 5 | Active system size n, captured at start |
| done_i | input | 26 | Per-element completion flags; bit k belongs to row k+1 |
| phase_o | output | 2 | Phase code: 0 idle, 1 initialization, 2 elimination, 3 return |
| ref_row_o | output | 5 | Current reference row, 1..n while busy |
| busy_o | output | 1 | A run is in progress |
| finished_o | output | 1 | One-cycle pulse after the last return step |

## Verification
Two events can land on the same clock edge: a fresh start request and the completion of the final return step. The bench raises start_i exactly on the edge that retires row n of the return phase. The expected result is that the edge produces the finished pulse and the idle state, and does not begin a new run. The next cycle must stay idle. The same edge is also checked from the other side: a start raised in the middle of a run must leave the phase and row unchanged while done is low.

// File: rtl/gj_seq_pkg.sv
package gj_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_ELIM = 2'd2,
    PH_RET  = 2'd3
  } phase_e;

  // Order in which the phases follow one another inside a run
  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_INIT: return PH_ELIM;
      PH_ELIM: return PH_RET;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/gj_seq_ctrl.sv
module gj_seq_ctrl #(
  parameter int MAX_ROWS = 26,
  parameter int ROW_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ROW_W-1:0]    size_i,
  input  logic [MAX_ROWS-1:0] done_i,
  input  logic                busy_i,
  output logic                start_acc_o,
  output logic                step_adv_o,
  output logic [ROW_W-1:0]    size_o
);

  // Rows 1..n are active; element k serves row k+1
  function automatic logic [MAX_ROWS-1:0] active_mask(input logic [ROW_W-1:0] n);
    logic [MAX_ROWS-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_ROWS; i++) m[i] = (ROW_W'(i) < n);
    return m;
  endfunction

  function automatic logic size_ok(input logic [ROW_W-1:0] n);
    return (n != '0) && (n <= ROW_W'(MAX_ROWS));
  endfunction

  logic [ROW_W-1:0] size_q;
  logic             all_done;

  assign all_done    = &(done_i | ~active_mask(size_q));
  assign start_acc_o = start_i && !busy_i && size_ok(size_i);
  assign step_adv_o  = busy_i && all_done;
  assign size_o      = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           size_q <= '0;
    else if (start_acc_o) size_q <= size_i;
  end

  // R3: an out-of-range size does not start a run
  p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && start_i && !size_ok(size_i)) |=> !busy_i);

  // R8: the captured size stays put while a run is in flight
  p_size_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(size_q));

endmodule

// File: rtl/gj_row_gen.sv
module gj_row_gen #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc_i,
  input  logic             step_adv_i,
  input  logic             run_end_i,
  input  logic             busy_i,
  input  logic [ROW_W-1:0] size_i,
  output logic [ROW_W-1:0] row_o,
  output logic             row_wrap_o
);

  logic [ROW_W-1:0] row_q;

  assign row_wrap_o = step_adv_i && (row_q == size_i);
  assign row_o      = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           row_q <= '0;
    else if (start_acc_i) row_q <= ROW_W'(1);
    else if (run_end_i)   row_q <= '0;
    else if (step_adv_i)  row_q <= row_wrap_o ? ROW_W'(1) : row_q + ROW_W'(1);
  end

  // R9: the reference row stays inside the active window
  p_row_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (row_q >= ROW_W'(1) && row_q <= size_i));

endmodule

// File: rtl/gj_phase_gen.sv
module gj_phase_gen
  import gj_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_acc_i,
  input  logic   row_wrap_i,
  output phase_e phase_o,
  output logic   busy_o,
  output logic   run_end_o,
  output logic   finished_o
);

  phase_e phase_q;
  logic   fin_q;

  assign busy_o     = (phase_q != PH_IDLE);
  assign run_end_o  = row_wrap_i && (phase_q == PH_RET);
  assign phase_o    = phase_q;
  assign finished_o = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= run_end_o;
      if (start_acc_i)     phase_q <= PH_INIT;
      else if (row_wrap_i) phase_q <= phase_after(phase_q);
    end
  end

  // R2: an accepted start enters initialization
  p_start_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_i |=> (phase_q == PH_INIT));

  // R5: initialization is followed by elimination, elimination by return
  p_init_to_elim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wrap_i && phase_q == PH_INIT) |=> (phase_q == PH_ELIM));
  p_elim_to_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wrap_i && phase_q == PH_ELIM) |=> (phase_q == PH_RET));

  // R6: finished is a single-cycle pulse that arrives in idle
  p_fin_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  p_fin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/gj_phase_sequencer.sv
module gj_phase_sequencer
  import gj_seq_pkg::*;
#(
  parameter int MAX_ROWS = 26,
  parameter int ROW_W    = $clog2(MAX_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ROW_W-1:0]    size_i,
  input  logic [MAX_ROWS-1:0] done_i,
  output logic [1:0]          phase_o,
  output logic [ROW_W-1:0]    ref_row_o,
  output logic                busy_o,
  output logic                finished_o
);

  // Internal events, named for the checks below
  logic             start_acc;
  logic             step_adv;
  logic             row_wrap;
  logic             run_end;
  logic [ROW_W-1:0] size_q;
  phase_e           phase;

  gj_seq_ctrl #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .size_i     (size_i),
    .done_i     (done_i),
    .busy_i     (busy_o),
    .start_acc_o(start_acc),
    .step_adv_o (step_adv),
    .size_o     (size_q)
  );

  gj_row_gen #(.ROW_W(ROW_W)) u_row (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc_i(start_acc),
    .step_adv_i (step_adv),
    .run_end_i  (run_end),
    .busy_i     (busy_o),
    .size_i     (size_q),
    .row_o      (ref_row_o),
    .row_wrap_o (row_wrap)
  );

  gj_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc_i(start_acc),
    .row_wrap_i (row_wrap),
    .phase_o    (phase),
    .busy_o     (busy_o),
    .run_end_o  (run_end),
    .finished_o (finished_o)
  );

  assign phase_o = phase;

  // R4: without a full set of active done bits nothing moves
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_adv) |=> ($stable(ref_row_o) && $stable(phase_o)));

  // R7: a start during a run does not send the row back to 1
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_adv) |=> $stable(ref_row_o));

endmodule

// File: tb/test_gj_phase_sequencer.sv
`timescale 1ns/1ps
module test_gj_phase_sequencer;

  localparam int MAXR = 26;
  localparam int RW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [RW-1:0]   size = '0;
  logic [MAXR-1:0] done = '0;
  logic [1:0]      phase;
  logic [RW-1:0]   row;
  logic            busy;
  logic            fin;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gj_phase_sequencer i_gj_phase_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .size_i(size), .done_i(done),
    .phase_o(phase), .ref_row_o(row), .busy_o(busy), .finished_o(fin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int ph, input int rw, input int bz);
    chk({req, " phase"}, phase, ph);
    chk({req, " row"},   row,   rw);
    chk({req, " busy"},  busy,  bz);
  endtask

  task automatic do_start(input int n);
    start = 1'b1; size = RW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    chk_state("R1", 0, 0, 0);
    chk("R1 finished", fin, 0);
  endtask

  // R2, R5, R6: full run with done held high
  task automatic t_full_run(input int n);
    done = '0;
    do_start(n);
    chk_state("R2", 1, 1, 1);
    done = '1;
    for (int k = 2; k <= 3 * n; k++) begin
      @(negedge clk);
      chk_state("R5", 1 + (k - 1) / n, 1 + (k - 1) % n, 1);
    end
    @(negedge clk);
    done = '0;
    chk_state("R6", 0, 0, 0);
    chk("R6 finished high", fin, 1);
    @(negedge clk);
    chk("R6 finished single", fin, 0);
  endtask

  // R3
  task automatic t_bad_size();
    do_start(0);
    chk_state("R3 size0", 0, 0, 0);
    do_start(27);
    chk_state("R3 size27", 0, 0, 0);
    do_start(31);
    chk_state("R3 size31", 0, 0, 0);
  endtask

  // R4: masking of done
  task automatic t_mask();
    done = '0;
    do_start(2);
    done = 26'h3FFFFFE;              // row 1 element not done, inactive all high
    @(negedge clk); @(negedge clk);
    chk_state("R4 hold", 1, 1, 1);
    done = 26'h0000001;              // only row 1 ready, row 2 missing
    @(negedge clk);
    chk_state("R4 partial", 1, 1, 1);
    done = 26'h0000003;              // both active ready, inactive low
    @(negedge clk);
    chk_state("R4 advance", 1, 2, 1);
    done = '0;
    @(negedge clk);
    chk_state("R4 hold2", 1, 2, 1);
    done = '1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    done = '0;
    chk("R4 finish", fin, 1);
  endtask

  // R7 mid-run, R8 size change
  task automatic t_busy_inputs();
    done = '0;
    do_start(3);
    done = '1;
    for (int k = 0; k < 3; k++) @(negedge clk);
    done = '0;
    chk_state("R7 pre", 2, 1, 1);
    start = 1'b1; size = 5'd5;
    @(negedge clk);
    start = 1'b0;
    chk_state("R7 start ignored", 2, 1, 1);
    size = 5'd26;                    // R8: should not lengthen the run
    done = '1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk_state("R8 last", 3, 3, 1);
    @(negedge clk);
    done = '0;
    chk("R8 finished on time", fin, 1);
    chk("R8 busy", busy, 0);
  endtask

  // R7: start on the edge of the final step
  task automatic t_start_at_end();
    done = '0;
    do_start(1);
    done = '1;
    @(negedge clk);
    chk_state("R5 n1", 2, 1, 1);
    @(negedge clk);
    chk_state("R5 n1", 3, 1, 1);
    start = 1'b1; size = 5'd4;
    @(negedge clk);
    start = 1'b0; done = '0;
    chk_state("R7 end edge", 0, 0, 0);
    chk("R7 end finished", fin, 1);
    @(negedge clk);
    chk_state("R7 stays idle", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_run(3);
    t_bad_size();
    t_mask();
    t_busy_inputs();
    t_start_at_end();
    t_full_run(26);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule